// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupts

This block is one bank of general-purpose I/O pins, read and written over a simple memory-mapped register bus. Software drives pins through a data-out register and an output-enable register, and it reads the pins back through a data-in register. Each pin can also be set up as an interrupt source. A pin reports either an active level or an edge, active high/rising or active low/falling, once it has been selected for interrupt use. Sticky status bits record the events. One shared interrupt line rises whenever an enabled status bit is set.

All registers sit in 16-byte groups. Inside each group, offset 0x0 is a plain write, offset 0x4 ORs the written ones into the register, and offset 0x8 clears the bits written as one. A read at any of these offsets returns the register itself. Pin inputs are resynchronised before use. An edge is found by comparing two consecutive synchronised samples.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe_o` and `pin_o` are zero and `irq_o` is low.
- R2: The group base is byte address 16*g, with g: 0 data-out, 1 data-in, 2 output-enable, 3 irq-select, 4 irq-enable, 5 irq-level, 6 irq-polarity, 7 irq-status. Offset +0x0 replaces the register, +0x4 sets the bits written as one, and +0x8 clears them. A read at +0x0, +0x4 or +0x8 returns the register value.
- R3: A read of data-in returns the pin values through a two-flop synchronizer. A pin change applied before clock edge k appears in the read after edge k+1 and not earlier.
- R4: `pin_o` equals data-out and `pin_oe_o` equals output-enable at all times.
- R5: Per pin, the level bit (irq-level) chooses level mode when 1 and edge mode when 0. The polarity bit (irq-polarity) chooses high/rising when 1 and low/falling when 0. In rising-edge mode (level 0, polarity 1), a 0-to-1 pin transition sets the status bit one edge after the change reaches the synchronizer output. A 1-to-0 transition does not set it.
- R6: In falling-edge mode (level 0, polarity 0), a 1-to-0 pin transition sets the status bit.
- R7: In level mode (level 1; polarity 1 high, 0 low), the status bit is set again every cycle while the pin is at its active level. A clear has lasting effect only after the pin has left that level.
- R8: A pin whose irq-select bit is 0 never sets its status bit.
- R9: Status bits are cleared only by writing ones to the status clear offset (0x78). Writes to 0x70 and 0x74 leave status unchanged.
- R10: `irq_o` is high exactly when some bit of status AND irq-enable is set. A pin that is not enabled still latches status without raising `irq_o`.
- R11: When a detection event and a clear of the same status bit occur on the same clock edge, the bit ends up set.
- R12: Writes to data-in, writes to group offset +0xC, and writes at addresses with bits [1:0] nonzero change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Write strobe qualifier |
| bus_we_i | input | 1 | Write enable |
| bus_addr_i | input | AW (12) | Byte address |
| bus_wdata_i | input | NPIN (32) | Write data |
| bus_rdata_o | output | NPIN (32) | Read data, combinational from address |
| pin_i | input | NPIN (32) | Raw pin inputs |
| pin_o | output | NPIN (32) | Pin drive values |
| pin_oe_o | output | NPIN (32) | Pin drive enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The alias logic is tried with base writes, set-alias writes and clear-alias writes whose one-bits overlap previous contents. This separates OR, AND-NOT and replacement behaviour, and it covers ignored addresses. Detection is tried with a rising and a falling transition on each edge-mode pin. The opposite transition tells rising from falling and edge from level. Level pins are held at their active level across a clear, which exposes whether status is re-armed. A clear issued on the exact edge of a detected rise shows which side wins. An unselected pin and an unenabled pin show whether selection and enabling gate different stages.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NGRP    = 8;
  localparam int unsigned GRP_LSB = 4;
  localparam int unsigned OP_LSB  = 2;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_RSV = 2'd3
  } alias_op_e;

  typedef enum logic [2:0] {
    G_DOUT  = 3'd0,
    G_DIN   = 3'd1,
    G_OE    = 3'd2,
    G_ISEL  = 3'd3,
    G_IEN   = 3'd4,
    G_ILEV  = 3'd5,
    G_IPOL  = 3'd6,
    G_ISTAT = 3'd7
  } grp_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] smp_i,
  input  logic [NPIN-1:0] isel_i,
  input  logic [NPIN-1:0] ilev_i,
  input  logic [NPIN-1:0] ipol_i,
  output logic [NPIN-1:0] hit_o
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= smp_i;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise, fall, act_lvl, cond;
    assign rise    = smp_i[i] & ~prev_q[i];
    assign fall    = ~smp_i[i] & prev_q[i];
    assign act_lvl = ipol_i[i] ? smp_i[i] : ~smp_i[i];
    assign cond    = ilev_i[i] ? act_lvl : (ipol_i[i] ? rise : fall);
    assign hit_o[i] = isel_i[i] & cond;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN = 32,
  parameter int unsigned AW   = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] rdata_o,
  input  logic [NPIN-1:0] din_i,
  input  logic [NPIN-1:0] hit_i,
  output logic [NPIN-1:0] dout_o,
  output logic [NPIN-1:0] oe_o,
  output logic [NPIN-1:0] isel_o,
  output logic [NPIN-1:0] ien_o,
  output logic [NPIN-1:0] ilev_o,
  output logic [NPIN-1:0] ipol_o,
  output logic [NPIN-1:0] stat_o
);
  localparam int unsigned TOP_LSB = GRP_LSB + $clog2(NGRP);

  logic            in_rng, wen;
  alias_op_e       op;
  grp_e            grp;
  logic [NPIN-1:0] regs_v [NGRP];

  assign in_rng = (addr_i[AW-1:TOP_LSB] == '0) && (addr_i[1:0] == 2'b00);
  assign op     = alias_op_e'(addr_i[OP_LSB +: 2]);
  assign grp    = grp_e'(addr_i[GRP_LSB +: 3]);
  assign wen    = req_i & we_i & in_rng;

  function automatic logic [NPIN-1:0] apply(input logic [NPIN-1:0] cur,
                                            input alias_op_e o,
                                            input logic [NPIN-1:0] d);
    case (o)
      OP_WR:   return d;
      OP_SET:  return cur | d;
      OP_CLR:  return cur & ~d;
      default: return cur;
    endcase
  endfunction

  for (genvar g = 0; g < NGRP; g++) begin : g_reg
    if (g == int'(G_DIN)) begin : g_din
      assign regs_v[g] = din_i;
    end else if (g == int'(G_ISTAT)) begin : g_stat
      logic [NPIN-1:0] q, clr_m;
      assign clr_m = (wen && grp == G_ISTAT && op == OP_CLR) ? wdata_i : '0;
      // detection beats a same-edge clear
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= (q & ~clr_m) | hit_i;
      assign regs_v[g] = q;
    end else begin : g_cfg
      logic [NPIN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)                        q <= '0;
        else if (wen && grp == grp_e'(g))   q <= apply(q, op, wdata_i);
      assign regs_v[g] = q;
    end
  end

  assign rdata_o = (addr_i[AW-1:TOP_LSB] == '0) ? regs_v[grp] : '0;

  assign dout_o = regs_v[int'(G_DOUT)];
  assign oe_o   = regs_v[int'(G_OE)];
  assign isel_o = regs_v[int'(G_ISEL)];
  assign ien_o  = regs_v[int'(G_IEN)];
  assign ilev_o = regs_v[int'(G_ILEV)];
  assign ipol_o = regs_v[int'(G_IPOL)];
  assign stat_o = regs_v[int'(G_ISTAT)];
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int unsigned NPIN = 32,
  parameter int unsigned AW   = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_req_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [NPIN-1:0] bus_wdata_i,
  output logic [NPIN-1:0] bus_rdata_o,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] pin_oe_o,
  output logic            irq_o
);
  logic [NPIN-1:0] smp_w, hit_w;
  logic [NPIN-1:0] dout_w, oe_w, isel_w, ien_w, ilev_w, ipol_w, stat_w;

  gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (smp_w)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp_w),
    .isel_i(isel_w),
    .ilev_i(ilev_w),
    .ipol_i(ipol_w),
    .hit_o (hit_w)
  );

  gpio_regs #(.NPIN(NPIN), .AW(AW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (bus_req_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .din_i  (smp_w),
    .hit_i  (hit_w),
    .dout_o (dout_w),
    .oe_o   (oe_w),
    .isel_o (isel_w),
    .ien_o  (ien_w),
    .ilev_o (ilev_w),
    .ipol_o (ipol_w),
    .stat_o (stat_w)
  );

  assign pin_o    = dout_w;
  assign pin_oe_o = oe_w;
  assign irq_o    = |(stat_w & ien_w);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NPIN = 32,
  parameter int unsigned AW   = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [NPIN-1:0] stat_i,
  input logic [NPIN-1:0] ien_i,
  input logic [NPIN-1:0] isel_i,
  input logic [NPIN-1:0] oe_i,
  input logic [NPIN-1:0] hit_i,
  input logic            irq_i
);
  localparam logic [AW-1:0] STAT_CLR_A = AW'(12'h078);
  localparam logic [AW-1:0] OE_SET_A   = AW'(12'h024);

  logic stat_clr_wr, oe_set_wr;
  assign stat_clr_wr = req_i & we_i & (addr_i == STAT_CLR_A);
  assign oe_set_wr   = req_i & we_i & (addr_i == OE_SET_A);

  a_r2_set_never_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oe_set_wr) |-> (($past(oe_i) & ~oe_i) == '0));

  a_r8_unselected_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_i & ~$past(stat_i) & ~$past(isel_i)) == '0));

  a_r9_clear_only_via_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(stat_i) & ~stat_i)) |-> $past(stat_clr_wr));

  a_r10_no_enable_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == '0) |-> !irq_i);

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(hit_i) & ~stat_i) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req_i (bus_req_i),
  .we_i  (bus_we_i),
  .addr_i(bus_addr_i),
  .stat_i(stat_w),
  .ien_i (ien_w),
  .isel_i(isel_w),
  .oe_i  (oe_w),
  .hit_i (hit_w),
  .irq_i (irq_o)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  localparam int NPIN = 32;
  localparam int AW   = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0, we = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [NPIN-1:0] wdata = '0, rdata, pins = '0, pin_o, pin_oe;
  logic            irq;
  int              n_chk = 0, n_fail = 0;
  bit              done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_bank #(.NPIN(NPIN), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pins), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // {write addr, write data, read addr, expected}
  localparam logic [87:0] VEC [8] = '{
    {12'h000, 32'hA5A5_0000, 12'h000, 32'hA5A5_0000},
    {12'h004, 32'h0000_00FF, 12'h000, 32'hA5A5_00FF},
    {12'h008, 32'h0500_000F, 12'h000, 32'hA0A5_00F0},
    {12'h00C, 32'hFFFF_FFFF, 12'h000, 32'hA0A5_00F0}, // R12 reserved offset
    {12'h020, 32'hFFFF_0000, 12'h020, 32'hFFFF_0000},
    {12'h028, 32'h0F00_0000, 12'h020, 32'hF0FF_0000},
    {12'h024, 32'h0000_0001, 12'h028, 32'hF0FF_0001},
    {12'h010, 32'hFFFF_FFFF, 12'h010, 32'h0000_0000}  // R12 data-in write
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int g = 0; g < 8; g++) begin
      rd(12'(g * 16), v);
      chk("R1 reg", v, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_o", pin_o, 32'h0);

    // R2 / R12 alias table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][87:76], VEC[i][75:44]);
      rd(VEC[i][43:32], v);
      chk((i == 3 || i == 7) ? "R12 table" : "R2 table", v, VEC[i][31:0]);
    end
    wr(12'h001, 32'hFFFF_FFFF); // R12 misaligned
    rd(12'h000, v);
    chk("R12 misaligned", v, 32'hA0A5_00F0);

    // R4 pin drive
    chk("R4 pin_o", pin_o, 32'hA0A5_00F0);
    chk("R4 pin_oe", pin_oe, 32'hF0FF_0001);

    // R3 synchronizer latency
    pins = 32'h0000_0100;
    @(negedge clk);
    rd(12'h010, v); chk("R3 one edge", v, 32'h0);
    @(negedge clk);
    rd(12'h010, v); chk("R3 two edges", v, 32'h0000_0100);

    // irq setup: p0 rise, p1 fall, p2 high, p3 low, p4 rise (not enabled), p7 unselected
    pins = 32'h0000_000A;
    wait_n(3);
    wr(12'h030, 32'hFFFF_FF7F);
    wr(12'h050, 32'h0000_000C);
    wr(12'h060, 32'h0000_0095);
    wr(12'h040, 32'h0000_000F);
    wr(12'h078, 32'hFFFF_FFFF);
    rd(12'h070, v); chk("R10 idle stat", v, 32'h0);
    chk("R10 idle irq", {31'h0, irq}, 32'h0);

    // R5 rising edge
    pins[0] = 1'b1;
    wait_n(2);
    chk("R5 not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    rd(12'h070, v); chk("R5 rise", v, 32'h1);
    chk("R10 irq on", {31'h0, irq}, 32'h1);
    pins[0] = 1'b0;
    wait_n(3);
    wr(12'h078, 32'h1);
    wait_n(3);
    rd(12'h070, v); chk("R5 fall ignored", v, 32'h0);
    chk("R10 irq off", {31'h0, irq}, 32'h0);

    // R6 falling edge
    pins[1] = 1'b0;
    wait_n(3);
    rd(12'h070, v); chk("R6 fall", v, 32'h2);
    wr(12'h078, 32'h2);
    rd(12'h070, v); chk("R6 cleared", v, 32'h0);

    // R7 high level
    pins[2] = 1'b1;
    wait_n(3);
    rd(12'h070, v); chk("R7 high", v, 32'h4);
    wr(12'h078, 32'h4);
    rd(12'h070, v); chk("R7 held rearms", v, 32'h4);
    pins[2] = 1'b0;
    wait_n(3);
    wr(12'h078, 32'h4);
    rd(12'h070, v); chk("R7 high released", v, 32'h0);

    // R7 low level
    pins[3] = 1'b0;
    wait_n(3);
    rd(12'h070, v); chk("R7 low", v, 32'h8);
    pins[3] = 1'b1;
    wait_n(3);
    wr(12'h078, 32'h8);
    rd(12'h070, v); chk("R7 low released", v, 32'h0);

    // R8 unselected pin
    pins[7] = 1'b1;
    wait_n(4);
    rd(12'h070, v); chk("R8 unselected", v, 32'h0);
    chk("R8 irq", {31'h0, irq}, 32'h0);

    // R10 latched but not enabled
    pins[4] = 1'b1;
    wait_n(3);
    rd(12'h070, v); chk("R10 latched", v, 32'h10);
    chk("R10 masked", {31'h0, irq}, 32'h0);
    wr(12'h044, 32'h10);
    chk("R10 enabled", {31'h0, irq}, 32'h1);

    // R9 only clear alias clears status
    wr(12'h070, 32'h0);
    rd(12'h070, v); chk("R9 base write", v, 32'h10);
    wr(12'h074, 32'hFFFF_FFFF);
    rd(12'h070, v); chk("R9 set write", v, 32'h10);
    wr(12'h078, 32'h10);
    rd(12'h070, v); chk("R9 clear", v, 32'h0);
    chk("R9 irq", {31'h0, irq}, 32'h0);

    // R11 same-edge set and clear
    pins[0] = 1'b1;
    wait_n(2);
    wr(12'h078, 32'h1);
    rd(12'h070, v); chk("R11 set wins", v, 32'h1);
    wr(12'h078, 32'h1);
    rd(12'h070, v); chk("R11 later clear", v, 32'h0);

    finish_run();
  end
endmodule